// File: doc/BRIEF.md
# Priority Memory Map Decoder

This block sits between a 16-bit CPU address bus and the storage of a small controller. It maps each address to one of four regions: a 64-byte window of I/O registers, an EEPROM window, a non-volatile RAM window and a relocatable RAM window. The regions may overlap. A fixed priority picks exactly one winner, so downstream storage needs only the one-hot select and an offset within its own region.

An 8-bit mapping register moves two of the windows at run time. Its low nibble sets address bits 15:12 of the I/O window base. Its high nibble sets address bits 15:12 of the RAM window base. The CPU writes this register through a fixed offset inside the I/O window, and every later access decodes against the new layout. The EEPROM and non-volatile RAM windows are fixed by parameters. An address that falls in no window raises a no-select flag.

Top module: `prio_map_decoder`

## Requirements
- R1: After reset the mapping register holds 0x01. This places the I/O window at 0x1000 and the RAM window at 0x0000.
- R2: The I/O window starts at (mapping register bits 3:0) × 0x1000 and covers 64 addresses. An address inside it drives sel bit 0.
- R3: The RAM window starts at (mapping register bits 7:4) × 0x1000 and covers RAM_SIZE addresses (default 1024). It drives sel bit 3.
- R4: The EEPROM window covers EE_BASE..EE_BASE+EE_SIZE-1 (default 0xB600, 512 bytes) and drives sel bit 1. The non-volatile RAM window covers NV_BASE..NV_BASE+NV_SIZE-1 (default 0xB000, 4096 bytes) and drives sel bit 2.
- R5: Where windows overlap, the priority is I/O, then EEPROM, then non-volatile RAM, then RAM. At most one sel bit is set.
- R6: offset equals the address minus the base of the selected window. It is 0 when no window is selected.
- R7: When the address lies in no window, none is 1 and sel is 0. Otherwise none is 0.
- R8: A write with wr_en set, at I/O window offset 0x3D, loads wr_data into the mapping register. Decoding uses the new value from the cycle after the write edge. In the write cycle itself, decoding still uses the old value.
- R9: wr_en at any other address, including other I/O window offsets, leaves the mapping register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 16 | CPU address |
| wr_en | input | 1 | CPU write strobe |
| wr_data | input | 8 | CPU write data |
| sel | output | 4 | One-hot region select: bit0 I/O, bit1 EEPROM, bit2 NV RAM, bit3 RAM |
| offset | output | 16 | Address relative to the selected window base |
| none | output | 1 | No window decodes the address |

## Verification
Every one of the 65536 addresses is swept under five mapping values. 0x01 gives disjoint windows. 0xB0 places RAM under the non-volatile window, so non-volatile RAM must win. 0xBB places I/O over both the non-volatile RAM and RAM windows. 0xFF overlays I/O on RAM at the top of memory, where the offset must wrap correctly. 0x3C moves both windows to fresh positions. Together these sweeps separate a wrong base nibble, a wrong window size, a wrong priority order and a wrong offset base. Writes to the register offset, to a neighbouring I/O offset and to RAM distinguish a correct load from an early, a late or a stray update.

// File: rtl/prio_map_decoder.sv
module prio_map_decoder #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_SPAN  = 64,
  parameter int unsigned MAP_OFS  = 61,
  parameter logic [7:0]  MAP_RST  = 8'h01,
  parameter logic [ADDR_W-1:0] EE_BASE = 16'hB600,
  parameter int unsigned EE_SIZE  = 512,
  parameter logic [ADDR_W-1:0] NV_BASE = 16'hB000,
  parameter int unsigned NV_SIZE  = 4096,
  parameter int unsigned RAM_SIZE = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  output logic [3:0]        sel,
  output logic [ADDR_W-1:0] offset,
  output logic              none
);
  localparam int unsigned LOW_W = ADDR_W - 4;
  localparam logic [ADDR_W:0] IO_LIM  = IO_SPAN[ADDR_W:0];
  localparam logic [ADDR_W:0] EE_LIM  = EE_SIZE[ADDR_W:0];
  localparam logic [ADDR_W:0] NV_LIM  = NV_SIZE[ADDR_W:0];
  localparam logic [ADDR_W:0] RAM_LIM = RAM_SIZE[ADDR_W:0];
  localparam logic [ADDR_W-1:0] MAP_OFF = MAP_OFS[ADDR_W-1:0];

  logic [7:0] map_q;
  logic [ADDR_W-1:0] io_base, ram_base;
  logic [ADDR_W-1:0] io_off, ee_off, nv_off, ram_off;
  logic io_hit, ee_hit, nv_hit, ram_hit;

  assign io_base  = {map_q[3:0], {LOW_W{1'b0}}};
  assign ram_base = {map_q[7:4], {LOW_W{1'b0}}};

  assign io_off  = addr - io_base;
  assign ee_off  = addr - EE_BASE;
  assign nv_off  = addr - NV_BASE;
  assign ram_off = addr - ram_base;

  assign io_hit  = {1'b0, io_off}  < IO_LIM;
  assign ee_hit  = {1'b0, ee_off}  < EE_LIM;
  assign nv_hit  = {1'b0, nv_off}  < NV_LIM;
  assign ram_hit = {1'b0, ram_off} < RAM_LIM;

  always_comb begin
    sel    = 4'b0000;
    offset = '0;
    if (io_hit) begin
      sel    = 4'b0001;
      offset = io_off;
    end else if (ee_hit) begin
      sel    = 4'b0010;
      offset = ee_off;
    end else if (nv_hit) begin
      sel    = 4'b0100;
      offset = nv_off;
    end else if (ram_hit) begin
      sel    = 4'b1000;
      offset = ram_off;
    end
  end

  assign none = ~(io_hit | ee_hit | nv_hit | ram_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)
      map_q <= MAP_RST;
    else if (wr_en && io_hit && io_off == MAP_OFF)
      map_q <= wr_data;
  end
endmodule

// File: rtl/prio_map_decoder_chk.sv
module prio_map_decoder_chk #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned IO_SPAN  = 64,
  parameter int unsigned RAM_SIZE = 1024,
  parameter int unsigned MAP_OFS  = 61,
  parameter logic [7:0]  MAP_RST  = 8'h01
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic [3:0]        sel,
  input logic [ADDR_W-1:0] offset,
  input logic              none,
  input logic [7:0]        map_q
);
  logic map_wr;
  assign map_wr = wr_en && sel[0] && (offset == MAP_OFS[ADDR_W-1:0]);

  // R1
  reset_value_chk: assert property (@(posedge clk) $rose(rst_n) |-> map_q == MAP_RST);
  // R5
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sel));
  // R7
  none_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) none == (sel == 4'b0000));
  // R6
  none_offset_chk: assert property (@(posedge clk) disable iff (!rst_n) none |-> offset == '0);
  // R2
  io_span_chk: assert property (@(posedge clk) disable iff (!rst_n) sel[0] |-> offset < IO_SPAN[ADDR_W-1:0]);
  // R3
  ram_span_chk: assert property (@(posedge clk) disable iff (!rst_n) sel[3] |-> offset < RAM_SIZE[ADDR_W-1:0]);
  // R8
  map_load_chk: assert property (@(posedge clk) disable iff (!rst_n) map_wr |=> map_q == $past(wr_data));
  // R9
  map_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !map_wr |=> $stable(map_q));
endmodule

bind prio_map_decoder prio_map_decoder_chk #(
  .ADDR_W(ADDR_W), .IO_SPAN(IO_SPAN), .RAM_SIZE(RAM_SIZE),
  .MAP_OFS(MAP_OFS), .MAP_RST(MAP_RST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .sel(sel), .offset(offset), .none(none), .map_q(map_q)
);

// File: tb/test_prio_map_decoder.sv
`timescale 1ns/1ps
module test_prio_map_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [3:0]  sel;
  logic [15:0] offset;
  logic        none;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] mdl_map;

  always #2.5 clk = ~clk;

  prio_map_decoder i_prio_map_decoder (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .sel(sel), .offset(offset), .none(none)
  );

  task automatic expect_at(input int a, input logic [7:0] m,
                           output logic [3:0] s, output logic [15:0] o, output string req);
    int io_b, ram_b, hits;
    io_b  = int'(m[3:0]) * 4096;
    ram_b = int'(m[7:4]) * 4096;
    hits = 0;
    if (a >= io_b && a < io_b + 64) hits++;
    if (a >= 'hB600 && a < 'hB800) hits++;
    if (a >= 'hB000 && a < 'hC000) hits++;
    if (a >= ram_b && a < ram_b + 1024) hits++;
    s = 4'b0000; o = 16'h0000;
    if (a >= io_b && a < io_b + 64) begin s = 4'b0001; o = 16'(a - io_b); req = "R2"; end
    else if (a >= 'hB600 && a < 'hB800) begin s = 4'b0010; o = 16'(a - 'hB600); req = "R4"; end
    else if (a >= 'hB000 && a < 'hC000) begin s = 4'b0100; o = 16'(a - 'hB000); req = "R4"; end
    else if (a >= ram_b && a < ram_b + 1024) begin s = 4'b1000; o = 16'(a - ram_b); req = "R3"; end
    else req = "R7";
    if (hits > 1) req = "R5";
  endtask

  task automatic check_addr(input int a, input string ctx);
    logic [3:0] s; logic [15:0] o; string req;
    expect_at(a, mdl_map, s, o, req);
    vectors++;
    if (sel !== s || offset !== o || none !== (s == 4'b0000)) begin
      fails++;
      $display("FAIL %s %s addr=%h map=%h sel=%b/%b offset=%h/%h none=%b/%b (got/exp)",
               req, ctx, a[15:0], mdl_map, sel, s, offset, o, none, s == 4'b0000);
    end
  endtask

  task automatic sweep(input string ctx);
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a);
      #1;
      check_addr(a, ctx);
    end
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d, input string ctx);
    @(negedge clk);
    addr = a; wr_en = 1'b1; wr_data = d;
    #1;
    check_addr(int'(a), {ctx, " R8 pre-edge old map"});
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    if (a == {mdl_map[3:0], 12'h000} + 16'h003D) mdl_map = d;
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    mdl_map = 8'h01;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1;
    // R1: reset layout, I/O at 0x1000, RAM at 0x0000
    addr = 16'h1000; #1; check_addr('h1000, "R1 io base after reset");
    addr = 16'h0000; #1; check_addr('h0000, "R1 ram base after reset");
    sweep("R1 map 01");
    // R9: stray writes into RAM and a neighbouring I/O offset
    cpu_write(16'h0000, 8'h55, "R9 ram write");
    cpu_write(16'h103C, 8'h66, "R9 io neighbour write");
    addr = 16'h1000; #1; check_addr('h1000, "R9 map unchanged");
    addr = 16'h0000; #1; check_addr('h0000, "R9 map unchanged");
    // R8: relocate, then new layout at once
    cpu_write(16'h103D, 8'hB0, "R8 to B0");
    addr = 16'h0000; #1; check_addr('h0000, "R8 new io base");
    addr = 16'h1000; #1; check_addr('h1000, "R8 old io gone");
    sweep("R5 map B0");
    cpu_write(16'h003D, 8'hBB, "R8 to BB");
    sweep("R5 map BB");
    cpu_write(16'hB03D, 8'hFF, "R8 to FF");
    sweep("R6 map FF");
    cpu_write(16'hF03D, 8'h3C, "R8 to 3C");
    sweep("R3 map 3C");
    cpu_write(16'h3C3D, 8'h00, "R9 wrong address");
    addr = 16'hC000; #1; check_addr('hC000, "R9 io still at C000");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule